// File: doc/BRIEF.md
# Lane-Configurable Command-Queued SPI Master

This block is a half-duplex SPI master that runs a list of small command words. The host writes commands into an operation queue, writes outgoing bytes into a transmit data queue and takes received bytes from a receive data queue. A sequencer pops one command at a time. Each command does one of five things: it sets the chip select level, emits bare clock pulses, shifts bytes out, shifts bytes in, or shifts bytes out and then turns the data lines around to receive. Transfers run on one, two or four data lanes.

A command word carries an opcode and a count. The host writes the word and pulses a push strobe while the queue-full flag is low. It can then poll a done flag, which is raised only after every queued command has finished on the wire. SCLK idles low. Each SPI clock lasts two core clocks, one with SCLK low and one with SCLK high. The outgoing lanes change while SCLK is low, and the design samples the incoming lanes at the end of the high phase. The queues are power-of-two deep.

Top module: `lane_spi_engine`

## Requirements
- R1: A command word has its opcode in bits 13:9 and a length of 0 to 511 in bits 8:0. A word is taken when op_push is high and op_full is low. Commands run in the order they were pushed.
- R2: After reset cs_n=1, sclk=0 and io_oe=0000. Opcode 0x00 sets cs_n to 1 and opcode 0x01 sets it to 0, whatever the length. cs_n never changes while sclk is high.
- R3: Opcode 0x02 produces exactly `length` SCLK pulses, each high for one core clock. It moves no data and leaves io_oe unchanged.
- R4: Opcodes 0x08, 0x09 and 0x0A send `length` bytes from the transmit queue, MSB first, on 1, 2 or 4 lanes, taking 8, 4 or 2 SCLK pulses per byte. Single mode uses io_out[0]. Dual mode uses io_out[1:0] and quad mode uses io_out[3:0], with the higher lane carrying the more significant bit. io_oe becomes 0001, 0011 or 1111.
- R5: Opcodes 0x0C, 0x0E and 0x0F receive `length` bytes, MSB first, and push each byte into the receive queue. Single mode reads io_in[1], dual mode io_in[1:0] and quad mode io_in[3:0]. Each clears the io_oe bits of the lanes it reads: 0010, 0011 or 1111 respectively.
- R6: Opcodes 0x10 to 0x18 send as in R4 with output width (opc-0x10)/3 and then clear the input-lane bits of input width (opc-0x10)%3. Width code 0 means one lane, 1 means two lanes and 2 means four lanes. For example, 0x16 leaves io_oe=1101 and 0x11 leaves io_oe=0000.
- R7: op_done is high only when the operation queue is empty and no command is executing. SCLK is low whenever op_done is high.
- R8: An output command whose transmit queue is empty waits with SCLK low. It resumes once a byte arrives, and no byte is dropped or repeated.
- R9: An input command waits with SCLK low before a byte while the receive queue is full. It resumes when the host pops a byte, and no byte is lost.
- R10: Any opcode not listed above is consumed with no effect. A data or clock command of length 0 finishes without any SCLK pulse and consumes no queued byte.
- R11: dq_rdata shows the oldest received byte while dq_empty is low, and dq_pop removes it. dq_full reports a full transmit queue. After reset op_full=0 and dq_empty=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| op_wdata | input | 14 | Command word to queue |
| op_push | input | 1 | Push op_wdata into the operation queue |
| op_full | output | 1 | Operation queue full |
| op_done | output | 1 | Queue empty and sequencer idle |
| dq_wdata | input | 8 | Byte for the transmit queue |
| dq_push | input | 1 | Push dq_wdata |
| dq_full | output | 1 | Transmit queue full |
| dq_rdata | output | 8 | Oldest received byte |
| dq_pop | input | 1 | Remove the oldest received byte |
| dq_empty | output | 1 | Receive queue empty |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data lane output values |
| io_oe | output | 4 | Data lane output enables |
| io_in | input | 4 | Data lane input values |

## Verification
Two pairs of events can land in the same core clock. In the first, the sequencer pushes a freshly assembled byte into the receive queue in the cycle where the host pops one. In the second, the sequencer takes a transmit byte in the cycle where the host pushes another. The bench runs a six-byte quad read against a four-entry receive queue and starts popping while the transfer is stalled, so pops and pushes overlap. It also starts a six-byte quad write with one byte queued and feeds the rest during the transfer. Both cases are judged by the scoreboard byte order and by the exact count of SCLK pulses.

// File: rtl/lse_pkg.sv
package lse_pkg;

    localparam int OPC_W  = 5;
    localparam int LEN_W  = 9;
    localparam int CMD_W  = OPC_W + LEN_W;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;

    typedef enum logic [2:0] {
        K_NOP, K_CS_HI, K_CS_LO, K_CLK, K_OUT, K_IN
    } kind_e;

    typedef enum logic [1:0] {
        LANE_X1 = 2'd0, LANE_X2 = 2'd1, LANE_X4 = 2'd2
    } lane_e;

    typedef enum logic [1:0] {
        S_IDLE, S_LOAD, S_LO, S_HI
    } seq_state_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [LEN_W-1:0] len;
    } cmd_t;

    typedef struct packed {
        kind_e kind;
        lane_e out_l;
        lane_e in_l;
        logic  turn;
    } dec_t;

    function automatic dec_t decode_op(input logic [OPC_W-1:0] opc);
        dec_t d;
        logic [OPC_W-1:0] idx;
        d.kind  = K_NOP;
        d.out_l = LANE_X1;
        d.in_l  = LANE_X1;
        d.turn  = 1'b0;
        idx     = opc - 5'h10;
        case (opc)
            5'h00: d.kind = K_CS_HI;
            5'h01: d.kind = K_CS_LO;
            5'h02: d.kind = K_CLK;
            5'h08, 5'h09, 5'h0A: begin
                d.kind  = K_OUT;
                d.out_l = lane_e'(opc[1:0]);
            end
            5'h0C: d.kind = K_IN;
            5'h0E: begin
                d.kind = K_IN;
                d.in_l = LANE_X2;
            end
            5'h0F: begin
                d.kind = K_IN;
                d.in_l = LANE_X4;
            end
            5'h10, 5'h11, 5'h12, 5'h13, 5'h14,
            5'h15, 5'h16, 5'h17, 5'h18: begin
                d.kind  = K_OUT;
                d.turn  = 1'b1;
                d.out_l = lane_e'(2'(idx / 5'd3));
                d.in_l  = lane_e'(2'(idx % 5'd3));
            end
            default: d.kind = K_NOP;
        endcase
        return d;
    endfunction

    // lanes driven by an output command of width l
    function automatic logic [LANES-1:0] drive_mask(input lane_e l);
        case (l)
            LANE_X1: return 4'b0001;
            LANE_X2: return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // lanes read by an input command of width l
    function automatic logic [LANES-1:0] sense_mask(input lane_e l);
        case (l)
            LANE_X1: return 4'b0010;
            LANE_X2: return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // SCLK pulses per byte, minus one
    function automatic logic [2:0] last_tick(input lane_e l);
        case (l)
            LANE_X1: return 3'd7;
            LANE_X2: return 3'd3;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/lse_fifo.sv
module lse_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
        end
    end
endmodule

// File: rtl/lse_sequencer.sv
module lse_sequencer
    import lse_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  cmd_t              cmd,
    output logic              cmd_pop,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_data,
    input  logic [LANES-1:0]  io_in,
    output logic              sclk,
    output logic              cs_n,
    output logic [LANES-1:0]  io_out,
    output logic [LANES-1:0]  io_oe,
    output logic              busy
);
    seq_state_e        st;
    kind_e             kind_q;
    lane_e             lane_q, tin_q;
    logic              turn_q, cs_q;
    logic [LEN_W-1:0]  left_q;
    logic [2:0]        tick_q;
    logic [BYTE_W-1:0] sh_q, sh_in, sh_out, sh_next;
    logic [LANES-1:0]  oe_q;
    dec_t              dc;

    assign dc = decode_op(cmd.opc);

    always_comb begin
        case (lane_q)
            LANE_X1: begin
                sh_in  = {sh_q[6:0], io_in[1]};
                sh_out = {sh_q[6:0], 1'b0};
                io_out = {3'b000, sh_q[7]};
            end
            LANE_X2: begin
                sh_in  = {sh_q[5:0], io_in[1:0]};
                sh_out = {sh_q[5:0], 2'b00};
                io_out = {2'b00, sh_q[7:6]};
            end
            default: begin
                sh_in  = {sh_q[3:0], io_in};
                sh_out = {sh_q[3:0], 4'b0000};
                io_out = sh_q[7:4];
            end
        endcase
        if (!(kind_q == K_OUT && (st == S_LO || st == S_HI))) io_out = '0;
        sh_next = (kind_q == K_IN) ? sh_in : sh_out;
    end

    assign cmd_pop = (st == S_IDLE) && cmd_valid;
    assign tx_pop  = (st == S_LOAD) && (kind_q == K_OUT) && tx_valid;
    assign rx_push = (st == S_HI) && (kind_q == K_IN) && (tick_q == 3'd0);
    assign rx_data = sh_in;
    assign sclk    = (st == S_HI);
    assign cs_n    = cs_q;
    assign io_oe   = oe_q;
    assign busy    = (st != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            kind_q <= K_NOP;
            lane_q <= LANE_X1;
            tin_q  <= LANE_X1;
            turn_q <= 1'b0;
            cs_q   <= 1'b1;
            left_q <= '0;
            tick_q <= '0;
            sh_q   <= '0;
            oe_q   <= '0;
        end else begin
            case (st)
                S_IDLE: if (cmd_valid) begin
                    case (dc.kind)
                        K_CS_HI: cs_q <= 1'b1;
                        K_CS_LO: cs_q <= 1'b0;
                        K_CLK, K_OUT, K_IN: begin
                            kind_q <= dc.kind;
                            lane_q <= (dc.kind == K_IN) ? dc.in_l : dc.out_l;
                            tin_q  <= dc.in_l;
                            turn_q <= dc.turn;
                            left_q <= cmd.len;
                            if (dc.kind == K_OUT) oe_q <= drive_mask(dc.out_l);
                            if (dc.kind == K_IN)  oe_q <= oe_q & ~sense_mask(dc.in_l);
                            if (cmd.len == '0) begin
                                if (dc.turn)
                                    oe_q <= drive_mask(dc.out_l) & ~sense_mask(dc.in_l);
                            end else begin
                                st <= S_LOAD;
                            end
                        end
                        default: ;
                    endcase
                end
                S_LOAD: begin
                    case (kind_q)
                        K_CLK: begin
                            tick_q <= '0;
                            st     <= S_LO;
                        end
                        K_OUT: if (tx_valid) begin
                            sh_q   <= tx_data;
                            tick_q <= last_tick(lane_q);
                            st     <= S_LO;
                        end
                        K_IN: if (!rx_full) begin
                            sh_q   <= '0;
                            tick_q <= last_tick(lane_q);
                            st     <= S_LO;
                        end
                        default: st <= S_IDLE;
                    endcase
                end
                S_LO: st <= S_HI;
                S_HI: begin
                    sh_q <= sh_next;
                    if (tick_q == 3'd0) begin
                        if (left_q == LEN_W'(1)) begin
                            st <= S_IDLE;
                            if (turn_q) oe_q <= oe_q & ~sense_mask(tin_q);
                        end else begin
                            left_q <= left_q - 1'b1;
                            st     <= S_LOAD;
                        end
                    end else begin
                        tick_q <= tick_q - 1'b1;
                        st     <= S_LO;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lane_spi_engine.sv
module lane_spi_engine
    import lse_pkg::*;
#(
    parameter int OPQ_DEPTH = 8,
    parameter int DQ_DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  op_wdata,
    input  logic              op_push,
    output logic              op_full,
    output logic              op_done,
    input  logic [BYTE_W-1:0] dq_wdata,
    input  logic              dq_push,
    output logic              dq_full,
    output logic [BYTE_W-1:0] dq_rdata,
    input  logic              dq_pop,
    output logic              dq_empty,
    output logic              sclk,
    output logic              cs_n,
    output logic [LANES-1:0]  io_out,
    output logic [LANES-1:0]  io_oe,
    input  logic [LANES-1:0]  io_in
);
    logic [CMD_W-1:0]  op_rdata;
    logic              op_empty, op_pop;
    logic [BYTE_W-1:0] tx_data, rx_wdata;
    logic              tx_empty, tx_pop, rx_push, rx_full, busy;

    lse_fifo #(.W(CMD_W), .DEPTH(OPQ_DEPTH)) opq_i (
        .clk(clk), .rst(rst), .push(op_push), .wdata(op_wdata), .pop(op_pop),
        .rdata(op_rdata), .full(op_full), .empty(op_empty)
    );

    lse_fifo #(.W(BYTE_W), .DEPTH(DQ_DEPTH)) txq_i (
        .clk(clk), .rst(rst), .push(dq_push), .wdata(dq_wdata), .pop(tx_pop),
        .rdata(tx_data), .full(dq_full), .empty(tx_empty)
    );

    lse_fifo #(.W(BYTE_W), .DEPTH(DQ_DEPTH)) rxq_i (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_wdata), .pop(dq_pop),
        .rdata(dq_rdata), .full(rx_full), .empty(dq_empty)
    );

    lse_sequencer seq_i (
        .clk(clk), .rst(rst),
        .cmd_valid(!op_empty), .cmd(cmd_t'(op_rdata)), .cmd_pop(op_pop),
        .tx_valid(!tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_wdata),
        .io_in(io_in), .sclk(sclk), .cs_n(cs_n), .io_out(io_out),
        .io_oe(io_oe), .busy(busy)
    );

    assign op_done = op_empty && !busy;
endmodule

// File: rtl/lse_checker.sv
module lse_checker (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic cs_n,
    input logic op_done,
    input logic tx_pop,
    input logic tx_empty,
    input logic rx_push,
    input logic rx_full
);
    p_sclk_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        sclk |=> !sclk);

    p_cs_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(cs_n) |-> !sclk);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        op_done |-> !sclk);

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> !tx_empty);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full);
endmodule

bind lane_spi_engine lse_checker chk_i (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .op_done(op_done),
    .tx_pop(tx_pop), .tx_empty(tx_empty), .rx_push(rx_push), .rx_full(rx_full)
);

// File: tb/lane_spi_engine_tb_top.sv
`timescale 1ns/1ps
module lane_spi_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [13:0] op_wdata = '0;
    logic       op_push = 1'b0, op_full, op_done;
    logic [7:0] dq_wdata = '0, dq_rdata;
    logic       dq_push = 1'b0, dq_full, dq_pop = 1'b0, dq_empty;
    logic       sclk, cs_n;
    logic [3:0] io_out, io_oe, io_in;

    always #2.5 clk = ~clk;

    lane_spi_engine #(.OPQ_DEPTH(4), .DQ_DEPTH(4)) dut_i (
        .clk(clk), .rst(rst), .op_wdata(op_wdata), .op_push(op_push),
        .op_full(op_full), .op_done(op_done), .dq_wdata(dq_wdata),
        .dq_push(dq_push), .dq_full(dq_full), .dq_rdata(dq_rdata),
        .dq_pop(dq_pop), .dq_empty(dq_empty), .sclk(sclk), .cs_n(cs_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    int n_tests = 0, n_fail = 0;
    int sclk_edges = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard for transmitted bytes
    byte unsigned exp_q[$];
    logic       mon_en = 1'b0;
    int         mon_w = 1, mon_cnt = 0;
    logic [7:0] mon_acc = '0;

    always @(posedge sclk) begin
        sclk_edges++;
        if (mon_en) begin
            case (mon_w)
                1: mon_acc = {mon_acc[6:0], io_out[0]};
                2: mon_acc = {mon_acc[5:0], io_out[1:0]};
                default: mon_acc = {mon_acc[3:0], io_out};
            endcase
            mon_cnt += mon_w;
            if (mon_cnt == 8) begin
                mon_cnt = 0;
                if (exp_q.size() == 0) check("R4 unexpected byte", {24'd0, mon_acc}, 32'hFFFF);
                else check("R4 tx byte", {24'd0, mon_acc}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    // SPI target model for receive
    byte unsigned sl_q[$];
    byte unsigned exp_rx[$];
    logic       sl_en = 1'b0;
    int         sl_w = 1, sl_cnt = 0;
    logic [7:0] sl_sh = '0;

    always_comb begin
        io_in = 4'b0000;
        if (sl_en) begin
            case (sl_w)
                1: io_in = {2'b00, sl_sh[7], 1'b0};
                2: io_in = {2'b00, sl_sh[7:6]};
                default: io_in = sl_sh[7:4];
            endcase
        end
    end

    always @(negedge sclk) begin
        if (sl_en) begin
            sl_sh = sl_sh << sl_w;
            sl_cnt += sl_w;
            if (sl_cnt == 8) begin
                sl_cnt = 0;
                sl_sh = (sl_q.size() != 0) ? sl_q.pop_front() : 8'h00;
            end
        end
    end

    task automatic slave_load(input int w, input byte unsigned b[$]);
        sl_w = w;
        sl_cnt = 0;
        foreach (b[i]) begin
            sl_q.push_back(b[i]);
            exp_rx.push_back(b[i]);
        end
        sl_sh = sl_q.pop_front();
        sl_en = 1'b1;
    endtask

    task automatic op(input logic [4:0] opc, input int len);
        while (op_full) @(negedge clk);
        op_wdata = {opc, 9'(len)};
        op_push = 1'b1;
        @(negedge clk);
        op_push = 1'b0;
    endtask

    task automatic txb(input logic [7:0] b);
        while (dq_full) @(negedge clk);
        exp_q.push_back(b);
        dq_wdata = b;
        dq_push = 1'b1;
        @(negedge clk);
        dq_push = 1'b0;
    endtask

    task automatic pop_rx(input string req);
        int g;
        g = 0;
        while (dq_empty && g < 2000) begin
            @(negedge clk);
            g++;
        end
        if (exp_rx.size() == 0) check(req, {24'd0, dq_rdata}, 32'hFFFF);
        else check(req, {24'd0, dq_rdata}, {24'd0, exp_rx.pop_front()});
        dq_pop = 1'b1;
        @(negedge clk);
        dq_pop = 1'b0;
    endtask

    task automatic wait_done();
        int g;
        g = 0;
        while (!op_done && g < 5000) begin
            @(negedge clk);
            g++;
        end
        if (!op_done) check("R7 completion", 0, 1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check("R2 reset cs_n", cs_n, 1);
        check("R2 reset sclk", sclk, 0);
        check("R2 reset io_oe", io_oe, 0);
        check("R7 reset done", op_done, 1);
        check("R11 reset op_full", op_full, 0);
        check("R11 reset dq_empty", dq_empty, 1);

        // R2 chip select low
        op(5'h01, 1); wait_done();
        check("R2 cs low", cs_n, 0);
        check("R2 no clocks", sclk_edges, 0);

        // R4 single output
        mon_en = 1'b1; mon_w = 1; mon_cnt = 0;
        base = sclk_edges;
        txb(8'hA5); txb(8'h3C);
        op(5'h08, 2); wait_done();
        check("R4 x1 edges", sclk_edges - base, 16);
        check("R4 x1 oe", io_oe, 4'b0001);
        check("R4 x1 drained", exp_q.size(), 0);

        // R4 dual output
        mon_w = 2; base = sclk_edges;
        txb(8'h96); txb(8'hE1);
        op(5'h09, 2); wait_done();
        check("R4 x2 edges", sclk_edges - base, 8);
        check("R4 x2 oe", io_oe, 4'b0011);

        // R4 quad output, R1 length
        mon_w = 4; base = sclk_edges;
        txb(8'h12); txb(8'hF0); txb(8'h4B);
        op(5'h0A, 3); wait_done();
        check("R1 R4 x4 edges", sclk_edges - base, 6);
        check("R4 x4 oe", io_oe, 4'b1111);
        check("R4 x4 drained", exp_q.size(), 0);

        // R3 clocks only
        mon_en = 1'b0; base = sclk_edges;
        op(5'h02, 5); wait_done();
        check("R3 clock count", sclk_edges - base, 5);
        check("R3 oe kept", io_oe, 4'b1111);
        check("R3 no rx data", dq_empty, 1);

        // R5 quad input
        base = sclk_edges;
        slave_load(4, '{8'h5A, 8'hC3});
        op(5'h0F, 2); wait_done(); sl_en = 1'b0;
        check("R5 x4 edges", sclk_edges - base, 4);
        check("R5 x4 oe", io_oe, 4'b0000);
        pop_rx("R5 x4 byte0"); pop_rx("R5 x4 byte1");

        // R5 single and dual input
        slave_load(1, '{8'hB4});
        op(5'h0C, 1); wait_done(); sl_en = 1'b0;
        pop_rx("R5 x1 byte");
        slave_load(2, '{8'h2D});
        op(5'h0E, 1); wait_done(); sl_en = 1'b0;
        pop_rx("R5 x2 byte");

        // R6 turnaround quad out -> single in
        mon_en = 1'b1; mon_w = 4; mon_cnt = 0;
        txb(8'h7E);
        op(5'h16, 1); wait_done();
        check("R6 oq2is oe", io_oe, 4'b1101);
        mon_en = 1'b0;
        slave_load(1, '{8'h81});
        op(5'h0C, 1); wait_done(); sl_en = 1'b0;
        check("R5 R6 oe after x1 in", io_oe, 4'b1101);
        pop_rx("R6 byte after turn");

        mon_en = 1'b1; mon_w = 1; mon_cnt = 0;
        txb(8'h55);
        op(5'h11, 1); wait_done();
        check("R6 os2id oe", io_oe, 4'b0000);
        mon_w = 2;
        txb(8'hC9);
        op(5'h13, 1); wait_done();
        check("R6 od2is oe", io_oe, 4'b0001);
        check("R6 drained", exp_q.size(), 0);

        // R10 unknown opcodes and zero length
        base = sclk_edges;
        op(5'h05, 3); op(5'h19, 2); op(5'h0D, 1); wait_done();
        check("R10 unknown edges", sclk_edges - base, 0);
        check("R10 unknown cs", cs_n, 0);
        check("R10 unknown oe", io_oe, 4'b0001);
        mon_w = 1;
        txb(8'hD2);
        op(5'h08, 0); wait_done();
        check("R10 zero length edges", sclk_edges - base, 0);
        op(5'h08, 1); wait_done();
        check("R10 byte kept edges", sclk_edges - base, 8);
        check("R10 byte kept", exp_q.size(), 0);

        // R8 transmit underrun stall
        base = sclk_edges;
        txb(8'h6F);
        op(5'h08, 2);
        idle(40);
        check("R8 stall edges", sclk_edges - base, 8);
        check("R8 stall sclk", sclk, 0);
        check("R8 stall busy", op_done, 0);
        txb(8'h90); wait_done();
        check("R8 resume edges", sclk_edges - base, 16);
        check("R8 drained", exp_q.size(), 0);

        // concurrent host push and engine pop
        mon_w = 4; base = sclk_edges;
        txb(8'h01);
        op(5'h0A, 6);
        txb(8'h23); txb(8'h45); txb(8'h67); txb(8'h89); txb(8'hAB);
        wait_done();
        check("R4 streamed edges", sclk_edges - base, 12);
        check("R4 streamed drained", exp_q.size(), 0);
        mon_en = 1'b0;

        // R9 receive overflow stall with concurrent pops
        base = sclk_edges;
        slave_load(4, '{8'h11, 8'h2E, 8'hC7, 8'h38, 8'h9D, 8'hF4});
        op(5'h0F, 6);
        idle(60);
        check("R9 stall edges", sclk_edges - base, 8);
        check("R9 stall sclk", sclk, 0);
        check("R9 stall busy", op_done, 0);
        for (int i = 0; i < 6; i++) pop_rx("R9 rx byte");
        wait_done(); sl_en = 1'b0;
        check("R9 total edges", sclk_edges - base, 12);
        check("R11 rx empty", dq_empty, 1);

        // R2 chip select high
        op(5'h00, 1); wait_done();
        check("R2 cs high", cs_n, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule